// File: doc/BRIEF.md
# Four-Channel DMA Register File with Byte-Serial Host Access

This block holds the programmable state of a four-channel DMA engine. Each channel has a 16-bit current address, a 16-bit current count, base copies of both, a mode setting and a mask bit. A host reaches all of it through an 8-bit register port. A shared byte pointer decides whether a given access to a 16-bit register touches its low byte or its high byte. The pointer flips after every such access, and a dedicated write port forces it back to the low byte.

The engine that performs the bus cycles pulses `step_i` together with a channel index once per transferred unit. The block then advances the channel: the address goes up by one and the count goes down by one. The count is programmed as length minus one. Terminal count happens when a step finds the count at zero. What follows depends on the channel mode. A single-transfer channel wraps its count to 0xFFFF and masks itself. An auto-initialising channel reloads its base values and stays enabled. A cascade channel never moves. Terminal count raises a one-cycle pulse on `tc_o` and sets a sticky status flag. Reading the status port clears the flags.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset all channels are masked (`mask_o` = 4'hF), every address, count and status byte reads zero, `tc_o` is zero, `dir_wr_o` is zero, and the byte pointer selects the low byte.
- R2: Any write to port 11 (clear-pointer) makes the next access to an address or count register use its low byte.
- R3: Port 2c holds the address and port 2c+1 the count of channel c. Each read or write of ports 0..7 flips the byte pointer: low byte first, high byte second. A write updates both the base and current copies of the selected byte. A read returns the current copy.
- R4: A write to port 9 (single mask) selects the channel with data bits [1:0]. It masks that channel when bit 2 is 1 and unmasks it when bit 2 is 0. Other channels are unaffected.
- R5: A write to port 10 (mode) selects the channel with data bits [1:0]. Bit 2 sets the direction (1 = transfer into memory, shown on `dir_wr_o`). Bits [4:3] set the mode: 0 single, 1 auto-initialise, 2 cascade, 3 behaves as single.
- R6: A step on an unmasked, non-cascade channel whose count is non-zero increments its current address and decrements its current count, each by one.
- R7: A step on an unmasked single-mode channel whose count is zero increments the address, sets the count to 0xFFFF, masks the channel, and pulses `tc_o` for that channel in the next cycle.
- R8: A step on an unmasked auto-initialise channel whose count is zero reloads the current address and count from the base copies, leaves the channel unmasked, and pulses `tc_o`.
- R9: A step on a masked channel or a cascade channel changes none of its registers and produces no terminal count.
- R10: Reading port 8 returns the terminal-count flags of channels 0..3 in bits [3:0] and clears them. This read does not move the byte pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | 4 | Host port index |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, valid in the cycle of the read strobe |
| step_i | input | 1 | One transfer unit completed |
| step_ch_i | input | 2 | Channel of the step |
| mask_o | output | 4 | Per-channel mask state |
| dir_wr_o | output | 4 | Per-channel direction bit from the mode register |
| tc_o | output | 4 | One-cycle terminal-count pulse per channel |

## Verification
The bench builds the block with its default of four channels. With four channels, every value of the 2-bit channel fields in the mask and mode bytes selects a real channel, and all eight register ports can be reached. Counts are kept small so that terminal count is reached often, in every mode. Raw single-byte accesses are mixed in, so the byte pointer is regularly left on the high byte before a clear or a read.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  typedef enum logic [1:0] {
    XM_SINGLE  = 2'd0,
    XM_AUTO    = 2'd1,
    XM_CASCADE = 2'd2,
    XM_RSVD    = 2'd3
  } xfer_mode_e;

  typedef struct packed {
    xfer_mode_e mode;
    logic       dir_wr;
  } chan_mode_t;

  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;

endpackage

// File: rtl/dma_host_decode.sv
module dma_host_decode
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int ADDR_W = $clog2(2 * NUM_CH + 4)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic                byte_hi_o,
  output logic [NUM_CH-1:0]   addr_wr_o,
  output logic [NUM_CH-1:0]   cnt_wr_o,
  output logic [NUM_CH-1:0]   mask_set_o,
  output logic [NUM_CH-1:0]   mask_clr_o,
  output logic [NUM_CH-1:0]   mode_wr_o,
  output chan_mode_t          mode_o,
  output logic                stat_rd_o
);

  localparam logic [ADDR_W-1:0] P_STAT  = ADDR_W'(2 * NUM_CH);
  localparam logic [ADDR_W-1:0] P_SMASK = ADDR_W'(2 * NUM_CH + 1);
  localparam logic [ADDR_W-1:0] P_MODE  = ADDR_W'(2 * NUM_CH + 2);
  localparam logic [ADDR_W-1:0] P_CLRFF = ADDR_W'(2 * NUM_CH + 3);

  logic reg_space, reg_acc, clr_ff;
  logic byte_hi_q;

  assign reg_space = addr_i < ADDR_W'(2 * NUM_CH);
  assign reg_acc   = (wr_i | rd_i) & reg_space;
  assign clr_ff    = wr_i & (addr_i == P_CLRFF);
  assign stat_rd_o = rd_i & (addr_i == P_STAT);
  assign byte_hi_o = byte_hi_q;
  assign mode_o    = '{mode: xfer_mode_e'(wdata_i[4:3]), dir_wr: wdata_i[2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      byte_hi_q <= 1'b0;
    else if (clr_ff)  byte_hi_q <= 1'b0;
    else if (reg_acc) byte_hi_q <= ~byte_hi_q;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_dec
    logic hit_reg, hit_sel;
    assign hit_reg       = wr_i & reg_space & (addr_i[ADDR_W-1:1] == (ADDR_W-1)'(c));
    assign hit_sel       = wdata_i[1:0] == 2'(c);
    assign addr_wr_o[c]  = hit_reg & ~addr_i[0];
    assign cnt_wr_o[c]   = hit_reg &  addr_i[0];
    assign mask_set_o[c] = wr_i & (addr_i == P_SMASK) & hit_sel &  wdata_i[2];
    assign mask_clr_o[c] = wr_i & (addr_i == P_SMASK) & hit_sel & ~wdata_i[2];
    assign mode_wr_o[c]  = wr_i & (addr_i == P_MODE) & hit_sel;
  end

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_wr_i,
  input  logic              cnt_wr_i,
  input  logic              byte_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              mode_wr_i,
  input  chan_mode_t        mode_i,
  input  logic              mask_set_i,
  input  logic              mask_clr_i,
  input  logic              step_i,
  output logic [REG_W-1:0]  cur_addr_o,
  output logic [REG_W-1:0]  cur_cnt_o,
  output logic              mask_o,
  output logic              dir_wr_o,
  output logic              casc_o,
  output logic              auto_o,
  output logic              tc_evt_o
);

  logic [REG_W-1:0] base_addr_q, cur_addr_q, base_cnt_q, cur_cnt_q;
  chan_mode_t       mode_q;
  logic             mask_q;
  logic             host_wr, advance;

  assign host_wr  = addr_wr_i | cnt_wr_i;
  assign casc_o   = mode_q.mode == XM_CASCADE;
  assign auto_o   = mode_q.mode == XM_AUTO;
  // host programming wins over a coincident step
  assign advance  = step_i & ~mask_q & ~casc_o & ~host_wr;
  assign tc_evt_o = advance & (cur_cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      cur_addr_q  <= '0;
      base_cnt_q  <= '0;
      cur_cnt_q   <= '0;
      mode_q      <= '{mode: XM_SINGLE, dir_wr: 1'b0};
      mask_q      <= 1'b1;
    end else begin
      if (addr_wr_i) begin
        if (byte_hi_i) begin
          base_addr_q[REG_W-1:BYTE_W] <= wdata_i;
          cur_addr_q[REG_W-1:BYTE_W]  <= wdata_i;
        end else begin
          base_addr_q[BYTE_W-1:0] <= wdata_i;
          cur_addr_q[BYTE_W-1:0]  <= wdata_i;
        end
      end
      if (cnt_wr_i) begin
        if (byte_hi_i) begin
          base_cnt_q[REG_W-1:BYTE_W] <= wdata_i;
          cur_cnt_q[REG_W-1:BYTE_W]  <= wdata_i;
        end else begin
          base_cnt_q[BYTE_W-1:0] <= wdata_i;
          cur_cnt_q[BYTE_W-1:0]  <= wdata_i;
        end
      end
      if (advance) begin
        if (tc_evt_o && auto_o) begin
          cur_addr_q <= base_addr_q;
          cur_cnt_q  <= base_cnt_q;
        end else begin
          cur_addr_q <= cur_addr_q + 1'b1;
          cur_cnt_q  <= cur_cnt_q - 1'b1;
        end
      end
      if (mode_wr_i) mode_q <= mode_i;
      if (mask_set_i)      mask_q <= 1'b1;
      else if (mask_clr_i) mask_q <= 1'b0;
      if (tc_evt_o && !auto_o) mask_q <= 1'b1;
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;
  assign mask_o     = mask_q;
  assign dir_wr_o   = mode_q.dir_wr;

endmodule

// File: rtl/dma_read_mux.sv
module dma_read_mux
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int ADDR_W = $clog2(2 * NUM_CH + 4)
) (
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         byte_hi_i,
  input  logic [NUM_CH-1:0][REG_W-1:0] cur_addr_i,
  input  logic [NUM_CH-1:0][REG_W-1:0] cur_cnt_i,
  input  logic [NUM_CH-1:0]            stat_i,
  output logic [BYTE_W-1:0]            rdata_o
);

  logic [REG_W-1:0] word;

  always_comb begin
    word = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(2 * c))     word = cur_addr_i[c];
      if (addr_i == ADDR_W'(2 * c + 1)) word = cur_cnt_i[c];
    end
    if (addr_i < ADDR_W'(2 * NUM_CH))
      rdata_o = byte_hi_i ? word[REG_W-1:BYTE_W] : word[BYTE_W-1:0];
    else if (addr_i == ADDR_W'(2 * NUM_CH))
      rdata_o = BYTE_W'(stat_i);
    else
      rdata_o = '0;
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = $clog2(2 * NUM_CH + 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  input  logic              step_i,
  input  logic [CH_W-1:0]   step_ch_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] dir_wr_o,
  output logic [NUM_CH-1:0] tc_o
);

  logic                         byte_hi, stat_rd;
  logic [NUM_CH-1:0]            addr_wr, cnt_wr, mask_set, mask_clr, mode_wr;
  logic [NUM_CH-1:0]            step_v, tc_evt, casc_v, auto_v;
  logic [NUM_CH-1:0]            stat_q, tc_q;
  logic [NUM_CH-1:0][REG_W-1:0] cur_addr, cur_cnt;
  chan_mode_t                   mode_wdata;

  dma_host_decode #(.NUM_CH(NUM_CH)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (host_wr_i),
    .rd_i       (host_rd_i),
    .addr_i     (host_addr_i),
    .wdata_i    (host_wdata_i),
    .byte_hi_o  (byte_hi),
    .addr_wr_o  (addr_wr),
    .cnt_wr_o   (cnt_wr),
    .mask_set_o (mask_set),
    .mask_clr_o (mask_clr),
    .mode_wr_o  (mode_wr),
    .mode_o     (mode_wdata),
    .stat_rd_o  (stat_rd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign step_v[c] = step_i & (step_ch_i == CH_W'(c));

    dma_channel u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .addr_wr_i  (addr_wr[c]),
      .cnt_wr_i   (cnt_wr[c]),
      .byte_hi_i  (byte_hi),
      .wdata_i    (host_wdata_i),
      .mode_wr_i  (mode_wr[c]),
      .mode_i     (mode_wdata),
      .mask_set_i (mask_set[c]),
      .mask_clr_i (mask_clr[c]),
      .step_i     (step_v[c]),
      .cur_addr_o (cur_addr[c]),
      .cur_cnt_o  (cur_cnt[c]),
      .mask_o     (mask_o[c]),
      .dir_wr_o   (dir_wr_o[c]),
      .casc_o     (casc_v[c]),
      .auto_o     (auto_v[c]),
      .tc_evt_o   (tc_evt[c])
    );
  end

  // new terminal counts win over a clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      tc_q   <= '0;
    end else begin
      stat_q <= (stat_rd ? '0 : stat_q) | tc_evt;
      tc_q   <= tc_evt;
    end
  end

  assign tc_o = tc_q;

  dma_read_mux #(.NUM_CH(NUM_CH)) u_rmux (
    .addr_i     (host_addr_i),
    .byte_hi_i  (byte_hi),
    .cur_addr_i (cur_addr),
    .cur_cnt_i  (cur_cnt),
    .stat_i     (stat_q),
    .rdata_o    (host_rdata_o)
  );

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = $clog2(2 * NUM_CH + 4)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         host_wr_i,
  input logic                         host_rd_i,
  input logic [ADDR_W-1:0]            host_addr_i,
  input logic [BYTE_W-1:0]            host_wdata_i,
  input logic                         step_i,
  input logic [CH_W-1:0]              step_ch_i,
  input logic [NUM_CH-1:0]            mask_o,
  input logic [NUM_CH-1:0]            tc_o,
  input logic                         byte_hi,
  input logic [NUM_CH-1:0][REG_W-1:0] cur_addr,
  input logic [NUM_CH-1:0][REG_W-1:0] cur_cnt,
  input logic [NUM_CH-1:0]            casc_v,
  input logic [NUM_CH-1:0]            auto_v
);

  p_ptr_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && host_addr_i == ADDR_W'(2 * NUM_CH + 3) |=> !byte_hi);

  p_ptr_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i || host_rd_i) && host_addr_i < ADDR_W'(2 * NUM_CH) |=> byte_hi != $past(byte_hi));

  p_ptr_status_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && !host_wr_i && host_addr_i == ADDR_W'(2 * NUM_CH) |=> $stable(byte_hi));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_unmask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      host_wr_i && host_addr_i == ADDR_W'(2 * NUM_CH + 1) && host_wdata_i[1:0] == 2'(c)
      && !host_wdata_i[2] && !step_i |=> !mask_o[c]);

    p_step_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i && step_ch_i == CH_W'(c) && !mask_o[c] && !casc_v[c] && !host_wr_i
      && cur_cnt[c] != '0 |=> cur_cnt[c] == $past(cur_cnt[c]) - 1'b1
      && cur_addr[c] == $past(cur_addr[c]) + 1'b1);

    p_single_tc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_o[c] && !$past(auto_v[c]) |-> mask_o[c] && cur_cnt[c] == '1);

    p_auto_tc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_o[c] && $past(auto_v[c]) && !$past(host_wr_i) |-> !mask_o[c]);

    p_cascade_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i && step_ch_i == CH_W'(c) && casc_v[c] && !host_wr_i
      |=> $stable(cur_addr[c]) && $stable(cur_cnt[c]) && !tc_o[c]);
  end

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_wr_i    (host_wr_i),
  .host_rd_i    (host_rd_i),
  .host_addr_i  (host_addr_i),
  .host_wdata_i (host_wdata_i),
  .step_i       (step_i),
  .step_ch_i    (step_ch_i),
  .mask_o       (mask_o),
  .tc_o         (tc_o),
  .byte_hi      (byte_hi),
  .cur_addr     (cur_addr),
  .cur_cnt      (cur_cnt),
  .casc_v       (casc_v),
  .auto_v       (auto_v)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       host_wr_i = 1'b0, host_rd_i = 1'b0;
  logic [3:0] host_addr_i = '0;
  logic [7:0] host_wdata_i = '0;
  logic [7:0] host_rdata_o;
  logic       step_i = 1'b0;
  logic [1:0] step_ch_i = '0;
  logic [3:0] mask_o, dir_wr_o, tc_o;

  int total = 0, bad = 0;
  logic [7:0] rd_val;

  // reference model
  logic [15:0] m_base_a [4], m_cur_a [4], m_base_c [4], m_cur_c [4];
  logic [1:0]  m_mode [4];
  logic [3:0]  m_mask, m_dir, m_stat;
  logic        m_ptr;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dma_chan_regs u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .host_wr_i(host_wr_i), .host_rd_i(host_rd_i),
    .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .step_i(step_i), .step_ch_i(step_ch_i), .mask_o(mask_o), .dir_wr_o(dir_wr_o), .tc_o(tc_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      m_base_a[c] = '0; m_cur_a[c] = '0; m_base_c[c] = '0; m_cur_c[c] = '0; m_mode[c] = '0;
    end
    m_mask = 4'hF; m_dir = '0; m_stat = '0; m_ptr = 1'b0;
  endtask

  // one bus cycle: drive at negedge, capture read data, release after posedge
  task automatic cyc(input logic wr, input logic rd, input logic [3:0] a, input logic [7:0] d,
                     input logic st, input logic [1:0] ch);
    @(negedge clk_i);
    host_wr_i = wr; host_rd_i = rd; host_addr_i = a; host_wdata_i = d;
    step_i = st; step_ch_i = ch;
    #1 rd_val = host_rdata_o;
    @(posedge clk_i);
    #1;
    host_wr_i = 1'b0; host_rd_i = 1'b0; step_i = 1'b0;
  endtask

  task automatic host_write(input logic [3:0] a, input logic [7:0] d);
    if (a < 8) begin
      int c = int'(a) / 2;
      if (a[0] == 1'b0) begin
        if (m_ptr) begin m_base_a[c][15:8] = d; m_cur_a[c][15:8] = d; end
        else       begin m_base_a[c][7:0]  = d; m_cur_a[c][7:0]  = d; end
      end else begin
        if (m_ptr) begin m_base_c[c][15:8] = d; m_cur_c[c][15:8] = d; end
        else       begin m_base_c[c][7:0]  = d; m_cur_c[c][7:0]  = d; end
      end
      m_ptr = ~m_ptr;
    end else if (a == 9) begin
      m_mask[d[1:0]] = d[2];
    end else if (a == 10) begin
      m_mode[d[1:0]] = d[4:3];
      m_dir[d[1:0]]  = d[2];
    end else if (a == 11) begin
      m_ptr = 1'b0;
    end
    cyc(1'b1, 1'b0, a, d, 1'b0, 2'd0);
    check("R4 mask_o after write", {28'd0, mask_o}, {28'd0, m_mask});
    check("R5 dir_wr_o after write", {28'd0, dir_wr_o}, {28'd0, m_dir});
  endtask

  task automatic host_read(input logic [3:0] a, input string tag);
    logic [7:0] exp;
    if (a < 8) begin
      int c = int'(a) / 2;
      logic [15:0] w = a[0] ? m_cur_c[c] : m_cur_a[c];
      exp = m_ptr ? w[15:8] : w[7:0];
      m_ptr = ~m_ptr;
    end else if (a == 8) begin
      exp = {4'd0, m_stat};
      m_stat = '0;
    end else begin
      exp = '0;
    end
    cyc(1'b0, 1'b1, a, 8'd0, 1'b0, 2'd0);
    check(tag, {24'd0, rd_val}, {24'd0, exp});
  endtask

  task automatic read16(input int c, input logic cnt, input string tag);
    host_write(4'd11, 8'h00);
    host_read(4'(2 * c + int'(cnt)), tag);
    host_read(4'(2 * c + int'(cnt)), tag);
  endtask

  task automatic write16(input int c, input logic cnt, input logic [15:0] v);
    host_write(4'd11, 8'h00);
    host_write(4'(2 * c + int'(cnt)), v[7:0]);
    host_write(4'(2 * c + int'(cnt)), v[15:8]);
  endtask

  task automatic do_step(input int c);
    logic [3:0] exp_tc = '0;
    if (!m_mask[c] && m_mode[c] != 2'd2) begin
      if (m_cur_c[c] == 16'h0) begin
        exp_tc[c] = 1'b1;
        m_stat[c] = 1'b1;
        if (m_mode[c] == 2'd1) begin
          m_cur_a[c] = m_base_a[c]; m_cur_c[c] = m_base_c[c];
        end else begin
          m_cur_a[c] = m_cur_a[c] + 1; m_cur_c[c] = 16'hFFFF; m_mask[c] = 1'b1;
        end
      end else begin
        m_cur_a[c] = m_cur_a[c] + 1; m_cur_c[c] = m_cur_c[c] - 1;
      end
    end
    cyc(1'b0, 1'b0, 4'd0, 8'd0, 1'b1, 2'(c));
    check("R7 R8 R9 tc_o after step", {28'd0, tc_o}, {28'd0, exp_tc});
    check("R7 R8 mask_o after step", {28'd0, mask_o}, {28'd0, m_mask});
  endtask

  function automatic logic [7:0] mode_byte(input int c, input logic [1:0] md, input logic dir);
    return {3'b000, md, dir, 2'(c)};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd2024);
    model_reset();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    check("R1 mask_o reset", {28'd0, mask_o}, 32'hF);
    check("R1 tc_o reset", {28'd0, tc_o}, 32'h0);
    check("R1 dir_wr_o reset", {28'd0, dir_wr_o}, 32'h0);
    host_read(4'd8, "R1 status reset");
    for (int c = 0; c < 4; c++) begin
      host_read(4'(2 * c), "R1 addr reset");
      host_read(4'(2 * c), "R1 addr reset");
      host_read(4'(2 * c + 1), "R1 count reset");
      host_read(4'(2 * c + 1), "R1 count reset");
    end

    // R3 low then high, base and current
    write16(1, 1'b0, 16'h1234);
    read16(1, 1'b0, "R3 address readback");
    // R2 clear after a dangling high-byte state
    host_write(4'd3, 8'h77);
    host_write(4'd11, 8'h00);
    host_read(4'd3, "R2 low byte after clear");
    // R10 status read leaves pointer where it was
    host_read(4'd8, "R10 status empty");
    host_read(4'd3, "R10 pointer kept across status read");

    // R4 mask / unmask single channel
    host_write(4'd9, 8'h02);
    host_write(4'd9, 8'h06);
    host_write(4'd9, 8'h03);

    // R5 mode with direction
    host_write(4'd10, mode_byte(2, 2'd0, 1'b1));

    // R6 R7 single mode terminal count
    host_write(4'd10, mode_byte(0, 2'd0, 1'b0));
    write16(0, 1'b0, 16'h00FE);
    write16(0, 1'b1, 16'h0002);
    host_write(4'd9, 8'h00);
    do_step(0); do_step(0);
    read16(0, 1'b1, "R6 count after two steps");
    do_step(0);
    read16(0, 1'b1, "R7 count wraps to ffff");
    read16(0, 1'b0, "R7 address after terminal count");
    host_read(4'd8, "R10 status shows tc");
    host_read(4'd8, "R10 status cleared by read");

    // R8 auto-initialise
    host_write(4'd10, mode_byte(1, 2'd1, 1'b0));
    write16(1, 1'b0, 16'h0100);
    write16(1, 1'b1, 16'h0001);
    host_write(4'd9, 8'h01);
    do_step(1); do_step(1);
    read16(1, 1'b0, "R8 address reloaded");
    read16(1, 1'b1, "R8 count reloaded");
    do_step(1);
    read16(1, 1'b0, "R8 address runs again");

    // R9 cascade and masked channel hold
    host_write(4'd10, mode_byte(3, 2'd2, 1'b0));
    write16(3, 1'b1, 16'h0000);
    host_write(4'd9, 8'h03);
    do_step(3);
    read16(3, 1'b1, "R9 cascade count held");
    do_step(2);
    read16(2, 1'b0, "R9 masked address held");

    // constrained random
    for (int i = 0; i < 1500; i++) begin
      int op = int'($urandom_range(0, 11));
      int c  = int'($urandom_range(0, 3));
      case (op)
        0:  host_write(4'(2 * c), 8'($urandom()));
        1:  write16(c, 1'b1, 16'($urandom_range(0, 3)));
        2:  host_write(4'd9, {5'd0, 1'($urandom_range(0, 3) == 0), 2'(c)});
        3:  host_write(4'd10, mode_byte(c, 2'($urandom_range(0, 3)), 1'($urandom())));
        4:  host_read(4'(2 * c + int'($urandom_range(0, 1))), "R3 raw read");
        5:  read16(c, 1'($urandom()), "R6 R7 R8 random readback");
        6:  host_read(4'd8, "R10 random status");
        7:  host_write(4'd11, 8'($urandom()));
        default: do_step(c);
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule